// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer on a plain 32-bit register port: a write strobe, a read strobe, a byte offset and a data word. Software writes the mode register to arm the timer and choose an interval. It then has to write a fixed reload pattern to the control register often enough to keep the countdown from reaching zero. If the countdown runs out and the config register selects the reset action, the block raises a system-reset output for a fixed number of cycles. It then stays halted until its own reset.

The mode and config registers ignore any write whose upper half-word does not hold the key value. The interval is picked with a 4-bit code from a non-linear table, counted in half-second ticks. The parameter `TICK_CYCLES` sets the number of clock cycles in one half-second tick, so a test can use small values.

A state machine drives the block. It has four states:
- `ST_IDLE`: the timer is stopped.
- `ST_RUN`: the countdown is active.
- `ST_FIRE`: the reset output is being driven.
- `ST_HALT`: the timer has expired and holds until reset.

Its transitions are:
- *start* (`ST_IDLE` to `ST_RUN`): the enable bit goes from 0 to 1.
- *kick* (`ST_RUN` to `ST_RUN`, with a reload): a valid reload pattern is written.
- *stop* (`ST_RUN` to `ST_IDLE`): a keyed mode write has the enable bit at 0.
- *expire-reset* (`ST_RUN` to `ST_FIRE`): the countdown ends with the reset action selected.
- *expire-quiet* (`ST_RUN` to `ST_HALT`): the countdown ends with any other action.
- *pulse-done* (`ST_FIRE` to `ST_HALT`): the reset pulse has finished.

Top module: `keyed_wdog`

## Requirements
- R1: The register offsets are 0x10 for control, 0x14 for config and 0x18 for mode. A write to any other offset has no effect.
  - Reads of control and of unmapped offsets return 0.
  - Config reads back its action field in bits [1:0].
  - Mode reads back the enable bit in bit 0 and the interval code in bits [7:4].
  - All other bits read as 0, including the key field.
- R2: A write to config or mode changes nothing unless wdata[31:16] equals 0x16AA.
- R3: A write to control reloads the countdown only when bit 0 is 1 and bits [12:1] equal 0xA57, that is wdata[12:0] = 0x14AF. Any other value leaves the countdown unchanged.
- R4: In `ST_IDLE`, a keyed mode write with bit 0 set starts the countdown. The stored enable bit must have been 0. The countdown is loaded from the code in that same write.
- R5: The interval in half-second ticks is as follows. Codes 0xC to 0xF act as 0xB.

  | Code | Half-second ticks |
  |------|-------------------|
  | 0x0 | 1 |
  | 0x1 to 0x6 | 2 × code |
  | 0x7 | 16 |
  | 0x8 | 20 |
  | 0x9 | 24 |
  | 0xA | 28 |
  | 0xB | 32 |

- R6: Expiry takes effect at the clock edge that lies N × `TICK_CYCLES` edges after the edge of the last start or reload, where N is the number of half-second ticks.
- R7: Changing the code while the timer runs does not move the current deadline. The new code applies from the next reload.
- R8: A keyed mode write with bit 0 clear returns the timer to `ST_IDLE`, and no expiry follows. If the same write also carries a reload, the stop wins.
- R9: On expiry with config action 01, `sys_rst_o` is high for exactly `RST_CYCLES` cycles. The block then stays in `ST_HALT` until `rst_n`, and no write changes that.
- R10: On expiry with any action other than 01, the block goes to `ST_HALT` without raising `sys_rst_o`.
- R11: After reset the block is in `ST_IDLE`, all registers read 0 and `sys_rst_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Single-cycle register write strobe |
| rd_en | input | 1 | Register read strobe; rdata is valid in the same cycle |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data; 0 when rd_en is low |
| sys_rst_o | output | 1 | System-reset request, high while in `ST_FIRE` |

## Verification
The hardest case to reach from the ports is an expiry deadline that depends on a reload and a code change interleaved during one countdown. The bench therefore rewrites the code while the timer runs, then kicks a few cycles later, and expects the deadline to follow the old code first and the new code only after the kick. A behavioural model tracks the deadline as an absolute cycle number and predicts `sys_rst_o` on every clock. This catches any off-by-one in the prescaler or the countdown, and any reset pulse that appears after a rejected reload pattern, an unkeyed write or a stop.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIRE = 2'd2,
        ST_HALT = 2'd3
    } kwd_state_e;

    localparam logic [7:0]  OFS_CTRL   = 8'h10;
    localparam logic [7:0]  OFS_CFG    = 8'h14;
    localparam logic [7:0]  OFS_MODE   = 8'h18;
    localparam logic [15:0] WR_KEY     = 16'h16AA;
    localparam logic [11:0] KICK_MAGIC = 12'hA57;
    localparam logic [1:0]  ACT_SYSRST = 2'b01;
    localparam int          HALF_W     = 6;

    // interval code -> number of half-second ticks
    function automatic logic [HALF_W-1:0] code_halves(input logic [3:0] c);
        logic [HALF_W-1:0] h;
        unique case (c)
            4'h0: h = 6'd1;
            4'h1: h = 6'd2;
            4'h2: h = 6'd4;
            4'h3: h = 6'd6;
            4'h4: h = 6'd8;
            4'h5: h = 6'd10;
            4'h6: h = 6'd12;
            4'h7: h = 6'd16;
            4'h8: h = 6'd20;
            4'h9: h = 6'd24;
            4'hA: h = 6'd28;
            default: h = 6'd32;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/kwd_regs.sv
module kwd_regs #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic [3:0]        code_q,
    output logic [1:0]        act_q,
    output logic              start_req,
    output logic              stop_req,
    output logic              kick_req,
    output logic [3:0]        start_code
);
    import kwd_pkg::*;

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFS_CFG);
    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFS_MODE);

    logic en_q;
    logic key_ok;
    logic mode_wr;
    logic cfg_wr;
    logic unused_bits;

    assign key_ok    = (wdata[31:16] == WR_KEY);
    assign mode_wr   = wr_en && (addr == A_MODE) && key_ok;
    assign cfg_wr    = wr_en && (addr == A_CFG) && key_ok;
    assign kick_req  = wr_en && (addr == A_CTRL) && wdata[0] && (wdata[12:1] == KICK_MAGIC);
    assign start_req = mode_wr && wdata[0] && !en_q;
    assign stop_req  = mode_wr && !wdata[0];
    assign start_code = wdata[7:4];
    assign unused_bits = ^{wdata[15:13], wdata[3:2]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            code_q <= 4'h0;
            act_q  <= 2'b00;
        end else begin
            if (mode_wr) begin
                en_q   <= wdata[0];
                code_q <= wdata[7:4];
            end
            if (cfg_wr) begin
                act_q <= wdata[1:0];
            end
        end
    end

    always_comb begin
        rdata = 32'h0;
        if (rd_en) begin
            if (addr == A_CFG) begin
                rdata = {30'h0, act_q};
            end else if (addr == A_MODE) begin
                rdata = {24'h0, code_q, 3'b000, en_q};
            end
        end
    end

endmodule

// File: rtl/kwd_count.sv
module kwd_count #(
    parameter int TICK_CYCLES = 8,
    parameter int CNT_W       = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic [CNT_W-1:0] cnt_o,
    output logic             expire_o
);
    localparam int PRE_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_CYCLES - 1);

    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] cnt_q;
    logic             tick;

    assign tick     = run && (pre_q == PRE_LAST);
    assign expire_o = tick && (cnt_q == CNT_W'(1)) && !load;
    assign cnt_o    = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            pre_q <= '0;
            cnt_q <= load_val;
        end else if (run) begin
            if (tick) begin
                pre_q <= '0;
                cnt_q <= cnt_q - CNT_W'(1);
            end else begin
                pre_q <= pre_q + PRE_W'(1);
            end
        end
    end

endmodule

// File: rtl/kwd_fsm.sv
module kwd_fsm #(
    parameter int RST_CYCLES = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_req,
    input  logic                      stop_req,
    input  logic                      kick_req,
    input  logic                      expire,
    input  logic [1:0]                act,
    input  logic [3:0]                code_q,
    input  logic [3:0]                start_code,
    output logic                      cnt_load,
    output logic [kwd_pkg::HALF_W-1:0] load_val,
    output logic                      cnt_run,
    output kwd_pkg::kwd_state_e       state_o,
    output logic                      sys_rst_o
);
    import kwd_pkg::*;

    localparam int PC_W = $clog2(RST_CYCLES + 1);
    localparam logic [PC_W-1:0] PC_LAST = PC_W'(RST_CYCLES - 1);

    kwd_state_e state_q, state_d;
    logic [PC_W-1:0] pcnt_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q <= '0;
        end else if (state_q != ST_FIRE) begin
            pcnt_q <= '0;
        end else begin
            pcnt_q <= pcnt_q + PC_W'(1);
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_req) state_d = ST_RUN;
            ST_RUN: begin
                if (stop_req) begin
                    state_d = ST_IDLE;
                end else if (kick_req) begin
                    state_d = ST_RUN;
                end else if (expire) begin
                    state_d = (act == ACT_SYSRST) ? ST_FIRE : ST_HALT;
                end
            end
            ST_FIRE: if (pcnt_q == PC_LAST) state_d = ST_HALT;
            ST_HALT: state_d = ST_HALT;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cnt_load  = ((state_q == ST_IDLE) && start_req) ||
                    ((state_q == ST_RUN) && kick_req && !stop_req);
        load_val  = (state_q == ST_IDLE) ? code_halves(start_code) : code_halves(code_q);
        cnt_run   = (state_q == ST_RUN);
        sys_rst_o = (state_q == ST_FIRE);
        state_o   = state_q;
    end

endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog #(
    parameter int ADDR_W      = 8,
    parameter int TICK_CYCLES = 12_000_000,
    parameter int RST_CYCLES  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              sys_rst_o
);
    import kwd_pkg::*;

    logic [3:0]        code_q;
    logic [1:0]        act_q;
    logic              start_req;
    logic              stop_req;
    logic              kick_req;
    logic [3:0]        start_code;
    logic              cnt_load;
    logic [HALF_W-1:0] load_val;
    logic              cnt_run;
    logic [HALF_W-1:0] cnt_val;
    logic              expire;
    kwd_state_e        fsm_state;

    kwd_regs #(.ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .code_q(code_q), .act_q(act_q),
        .start_req(start_req), .stop_req(stop_req), .kick_req(kick_req),
        .start_code(start_code)
    );

    kwd_count #(.TICK_CYCLES(TICK_CYCLES), .CNT_W(HALF_W)) count_i (
        .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(load_val),
        .run(cnt_run), .cnt_o(cnt_val), .expire_o(expire)
    );

    kwd_fsm #(.RST_CYCLES(RST_CYCLES)) fsm_i (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
        .kick_req(kick_req), .expire(expire), .act(act_q), .code_q(code_q),
        .start_code(start_code), .cnt_load(cnt_load), .load_val(load_val),
        .cnt_run(cnt_run), .state_o(fsm_state), .sys_rst_o(sys_rst_o)
    );

endmodule

// File: rtl/kwd_chk.sv
module kwd_chk #(
    parameter int ADDR_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   addr,
    input logic [15:0]         wkey,
    input logic                wlsb,
    input kwd_pkg::kwd_state_e state,
    input logic [5:0]          cnt,
    input logic                sys_rst_o
);
    import kwd_pkg::*;

    logic mode_hit;
    assign mode_hit = wr_en && (addr == ADDR_W'(OFS_MODE));

    // R2
    unkeyed_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && mode_hit && wkey != WR_KEY) |=> (state == ST_IDLE));

    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= 6'd32);

    // R8
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && mode_hit && wkey == WR_KEY && !wlsb) |=> (state == ST_IDLE));

    // R9
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT) |=> (state == ST_HALT && !sys_rst_o));

    // R9
    fire_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_o) |-> ($past(state) == ST_RUN));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !mode_hit) |=> $stable(cnt));

endmodule

bind keyed_wdog kwd_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wkey(wdata[31:16]), .wlsb(wdata[0]),
    .state(fsm_state), .cnt(cnt_val), .sys_rst_o(sys_rst_o)
);

// File: tb/keyed_wdog_tb.sv
module keyed_wdog_tb_top;

    localparam int TICK = 8;
    localparam int RST  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = 8'h0;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata;
    logic        sys_rst_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    keyed_wdog #(.ADDR_W(8), .TICK_CYCLES(TICK), .RST_CYCLES(RST)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .sys_rst_o(sys_rst_o)
    );

    // behavioural model: absolute deadline in clock edges
    int cyc, m_state, m_deadline, m_left, m_code, m_act;
    bit m_en;

    function automatic int halves(input int c);
        int k;
        k = c;
        if (k == 0) return 1;
        if (k < 7) return 2 * k;
        if (k > 11) k = 11;
        return 4 * k - 12;
    endfunction

    always @(posedge clk) begin
        bit keyed, mw, cw, kick;
        if (!rst_n) begin
            cyc = 0; m_state = 0; m_deadline = 0; m_left = 0;
            m_code = 0; m_act = 0; m_en = 1'b0;
        end else begin
            cyc++;
            keyed = (wdata[31:16] == 16'h16AA);
            mw    = wr_en && addr == 8'h18 && keyed;
            cw    = wr_en && addr == 8'h14 && keyed;
            kick  = wr_en && addr == 8'h10 && wdata[12:0] == 13'h14AF;
            case (m_state)
                0: if (mw && wdata[0] && !m_en) begin
                       m_state = 1;
                       m_deadline = cyc + halves(int'(wdata[7:4])) * TICK;
                   end
                1: begin
                       if (mw && !wdata[0]) m_state = 0;
                       else if (kick) m_deadline = cyc + halves(m_code) * TICK;
                       else if (cyc == m_deadline) begin
                           if (m_act == 1) begin m_state = 2; m_left = RST; end
                           else m_state = 3;
                       end
                   end
                2: begin
                       m_left--;
                       if (m_left == 0) m_state = 3;
                   end
                default: ;
            endcase
            if (mw) begin m_en = wdata[0]; m_code = int'(wdata[7:4]); end
            if (cw) m_act = int'(wdata[1:0]);
        end
    end

    // per-clock comparison of the reset output (R6, R9, R10, R11)
    always @(negedge clk) begin
        if (!done) begin
            logic exp_o;
            exp_o = rst_n && (m_state == 2);
            checks++;
            if (sys_rst_o !== exp_o) begin
                fails++;
                if (!rst_n) $display("FAIL R11 sys_rst_o in reset: actual %b expected %b", sys_rst_o, exp_o);
                else if (m_act == 1) $display("FAIL R6 R9 sys_rst_o at cycle %0d: actual %b expected %b", cyc, sys_rst_o, exp_o);
                else $display("FAIL R10 sys_rst_o at cycle %0d: actual %b expected %b", cyc, sys_rst_o, exp_o);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = 32'h0; addr = 8'h0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp_v, input string tag);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1;
        checks++;
        if (rdata !== exp_v) begin
            fails++;
            $display("FAIL %s read 0x%02h: actual 0x%08h expected 0x%08h", tag, a, rdata, exp_v);
        end
        rd_en = 1'b0; addr = 8'h0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
    endtask

    initial begin
        int wd;
        wd = 0;
        while (!done) begin
            @(posedge clk);
            wd++;
            if (wd > 100000) begin
                fails++;
                $display("FAIL watchdog expired");
                done = 1'b1;
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        do_reset();
        // R11 reset values
        rd_chk(8'h18, 32'h0, "R11");
        rd_chk(8'h14, 32'h0, "R11");
        // R2 unkeyed mode write ignored
        wr(8'h18, 32'h0000_0021);
        rd_chk(8'h18, 32'h0, "R2");
        // R1 wrong offset ignored
        wr(8'h1C, 32'h16AA_0021);
        rd_chk(8'h18, 32'h0, "R1");
        idle(40);
        // R1 R2 keyed config write, key reads as zero
        wr(8'h14, 32'h16AA_0001);
        rd_chk(8'h14, 32'h1, "R1");
        rd_chk(8'h10, 32'h0, "R1");
        rd_chk(8'h00, 32'h0, "R1");
        // R4 start with code 2 (32 cycles), R3 kick periodically
        wr(8'h18, 32'h16AA_0021);
        rd_chk(8'h18, 32'h21, "R4");
        for (int i = 0; i < 5; i++) begin
            idle(20);
            wr(8'h10, 32'h0000_14AF);
        end
        // R3 rejected reload patterns
        wr(8'h10, 32'h0000_14AE);
        wr(8'h10, 32'h0000_14AD);
        wr(8'h18, 32'h0000_14AF);
        idle(45);
        // R9 writes in halt change nothing
        wr(8'h10, 32'h0000_14AF);
        wr(8'h18, 32'h16AA_0000);
        wr(8'h18, 32'h16AA_0001);
        idle(50);

        // R8 stop before expiry, then restart with code 0
        do_reset();
        wr(8'h14, 32'h16AA_0001);
        wr(8'h18, 32'h16AA_0031);
        idle(20);
        wr(8'h18, 32'h16AA_0000);
        rd_chk(8'h18, 32'h0, "R8");
        idle(80);
        wr(8'h18, 32'h16AA_0001);
        idle(25);

        // R7 code change while running applies from next reload
        do_reset();
        wr(8'h14, 32'h16AA_0001);
        wr(8'h18, 32'h16AA_0021);
        idle(10);
        wr(8'h18, 32'h16AA_0001);
        idle(5);
        wr(8'h10, 32'h0000_14AF);
        idle(25);
        do_reset();
        wr(8'h14, 32'h16AA_0001);
        wr(8'h18, 32'h16AA_0021);
        wr(8'h18, 32'h16AA_0001);
        idle(45);

        // R5 clamp: code F behaves as B (256 cycles)
        do_reset();
        wr(8'h14, 32'h16AA_0001);
        wr(8'h18, 32'h16AA_00F1);
        idle(300);
        // R5 code 7 (128 cycles)
        do_reset();
        wr(8'h14, 32'h16AA_0001);
        wr(8'h18, 32'h16AA_0071);
        rd_chk(8'h18, 32'h71, "R5");
        idle(150);

        // R10 quiet expiry with action 00 and 10
        do_reset();
        wr(8'h18, 32'h16AA_0011);
        idle(40);
        do_reset();
        wr(8'h14, 32'h16AA_0002);
        rd_chk(8'h14, 32'h2, "R10");
        wr(8'h18, 32'h16AA_0001);
        idle(30);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule